// File: doc/BRIEF.md
# Raster Timing Generator for 640x480 Video

This block produces the beam timing for a 640 by 480 raster at a 25 MHz pixel clock, which gives a refresh rate close to 60 Hz. A column counter steps once per clock through an 800-clock line. A row counter steps once per line through a 521-line frame. From the two counters the block decodes a display-enable flag and two active-low sync pulses. It also blanks an 8-bit colour word (3 red, 3 green, 2 blue bits) to zero whenever the beam is outside the visible area.

The current column and row are driven straight from the counters. A pixel source uses them to look up the colour for that position and presents the colour on the input in the same cycle. The enable flag, both syncs and the gated colour are registered together, so all of them appear one clock after the coordinates they belong to. Every interval length is a parameter, and the defaults give the 640x480 timing.

Top module: `vga_raster_sync`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `col_o` and `row_o` are 0, `hsync_n_o` and `vsync_n_o` are 1, `de_o` is 0 and `rgb_o` is 0.
- R2: Out of reset, `col_o` increases by one each clock, from 0 up to 799, and then returns to 0.
- R3: `row_o` changes only in the clock after `col_o` was 799. It then increases by one, and it returns to 0 after 520.
- R4: `hsync_n_o` is low, one clock after the column, exactly for columns 656 through 751 (a 96-clock pulse, with 16 front-porch clocks before it and 48 back-porch clocks after it).
- R5: `vsync_n_o` is low, one clock after the coordinates, exactly while the row is 490 or 491 (2 lines, with 10 front-porch lines before them and 29 back-porch lines after them).
- R6: `de_o` is high, one clock after the coordinates, exactly when the column is below 640 and the row is below 480.
- R7: `rgb_o` equals the `rgb_i` value of the previous clock when that clock's coordinates were visible, and is 0 otherwise. Bits [7:5] are red, [4:2] are green and [1:0] are blue, and they pass through in place.
- R8: A reset raised in the middle of a frame brings both counters back to 0 and all outputs to their idle values at the next edge. Counting restarts from 0 after reset is released.
- R9: With other visible, porch and sync lengths given as parameters, R2 to R7 hold with the derived totals and sync positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| rgb_i | input | 8 | Colour for the current `col_o`/`row_o`, packed 3-3-2 |
| col_o | output | 10 | Current column, 0 to 799 |
| row_o | output | 10 | Current row, 0 to 520 |
| de_o | output | 1 | Registered display enable |
| hsync_n_o | output | 1 | Registered horizontal sync, active low |
| vsync_n_o | output | 1 | Registered vertical sync, active low |
| rgb_o | output | 8 | Registered colour, forced to zero outside the visible area |

## Verification
A column counter that is out of step shows at once on `col_o`. Within the same line it also shifts the horizontal pulse and the blanking edge, so a line-long run checked against independently computed positions catches it. A row counter that misses or repeats a step shows on `row_o` at the first line change, but the vertical pulse moves only once a whole frame has gone by. For that reason a second instance with a small geometry is run through many complete frames. A wrong pipeline stage shows as colour, enable or sync values that are off by one clock against the coordinates.

// File: rtl/vga_raster_pkg.sv
package vga_raster_pkg;

    typedef struct packed {
        logic [2:0] red;
        logic [2:0] grn;
        logic [1:0] blu;
    } rgb332_t;

    localparam int RGB_W = $bits(rgb332_t);

    typedef struct packed {
        logic vis;
        logic hs_act;
        logic vs_act;
    } beam_flags_t;

    localparam int DEF_H_VIS   = 640;
    localparam int DEF_H_FRONT = 16;
    localparam int DEF_H_SYNC  = 96;
    localparam int DEF_H_BACK  = 48;
    localparam int DEF_V_VIS   = 480;
    localparam int DEF_V_FRONT = 10;
    localparam int DEF_V_SYNC  = 2;
    localparam int DEF_V_BACK  = 29;

    function automatic logic in_span(int unsigned v, int unsigned lo, int unsigned len);
        return (v >= lo) && (v < lo + len);
    endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
    parameter int TOTAL = 800,
    localparam int W = $clog2(TOTAL)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] cnt,
    output logic         at_last
);

    assign at_last = (cnt == W'(TOTAL - 1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (adv)
            cnt <= at_last ? '0 : cnt + 1'b1;
    end

    // R2, R3: wrap to zero after the last count
    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && at_last) |=> (cnt == '0))
        else $error("counter did not wrap");

    // R3: counter holds while not advanced
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!adv && !$past(rst)) |=> $stable(cnt))
        else $error("counter moved without advance");

    assert_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= W'(TOTAL - 1))
        else $error("counter out of range");

endmodule

// File: rtl/span_decode.sv
module span_decode
    import vga_raster_pkg::*;
#(
    parameter int VIS   = 640,
    parameter int FRONT = 16,
    parameter int SYNC  = 96,
    parameter int W     = 10
) (
    input  logic [W-1:0] cnt,
    output logic         vis,
    output logic         sync_act
);

    localparam int SYNC_LO = VIS + FRONT;

    always_comb begin
        vis      = in_span(32'(cnt), 0, VIS);
        sync_act = in_span(32'(cnt), SYNC_LO, SYNC);
    end

endmodule

// File: rtl/pixel_gate.sv
module pixel_gate
    import vga_raster_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  beam_flags_t flags,
    input  rgb332_t     pix_i,
    output rgb332_t     pix_o,
    output logic        de_o,
    output logic        hsync_n_o,
    output logic        vsync_n_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_o     <= '0;
            de_o      <= 1'b0;
            hsync_n_o <= 1'b1;
            vsync_n_o <= 1'b1;
        end else begin
            pix_o     <= flags.vis ? pix_i : '0;
            de_o      <= flags.vis;
            hsync_n_o <= ~flags.hs_act;
            vsync_n_o <= ~flags.vs_act;
        end
    end

    // R7: colour is dark whenever enable is low
    assert_blank_R7: assert property (@(posedge clk) disable iff (rst)
        !de_o |-> (pix_o == '0))
        else $error("colour leaked outside visible area");

    // R1: reset leaves syncs idle and enable low
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (hsync_n_o && vsync_n_o && !de_o && pix_o == '0))
        else $error("outputs not idle after reset");

endmodule

// File: rtl/vga_raster_sync.sv
module vga_raster_sync
    import vga_raster_pkg::*;
#(
    parameter int H_VIS   = DEF_H_VIS,
    parameter int H_FRONT = DEF_H_FRONT,
    parameter int H_SYNC  = DEF_H_SYNC,
    parameter int H_BACK  = DEF_H_BACK,
    parameter int V_VIS   = DEF_V_VIS,
    parameter int V_FRONT = DEF_V_FRONT,
    parameter int V_SYNC  = DEF_V_SYNC,
    parameter int V_BACK  = DEF_V_BACK,
    localparam int H_TOTAL = H_VIS + H_FRONT + H_SYNC + H_BACK,
    localparam int V_TOTAL = V_VIS + V_FRONT + V_SYNC + V_BACK,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    rgb_i,
    output logic [HW-1:0] col_o,
    output logic [VW-1:0] row_o,
    output logic          de_o,
    output logic          hsync_n_o,
    output logic          vsync_n_o,
    output logic [7:0]    rgb_o
);

    localparam int H_SYNC_LO = H_VIS + H_FRONT;
    localparam int H_SYNC_HI = H_SYNC_LO + H_SYNC;
    localparam int V_SYNC_LO = V_VIS + V_FRONT;

    logic        h_last, v_last;
    logic        h_vis, h_sync, v_vis, v_sync;
    beam_flags_t flags;
    rgb332_t     pix_out;

    raster_counter #(.TOTAL(H_TOTAL)) u_hcnt (
        .clk(clk), .rst(rst), .adv(1'b1), .cnt(col_o), .at_last(h_last)
    );

    raster_counter #(.TOTAL(V_TOTAL)) u_vcnt (
        .clk(clk), .rst(rst), .adv(h_last), .cnt(row_o), .at_last(v_last)
    );

    span_decode #(.VIS(H_VIS), .FRONT(H_FRONT), .SYNC(H_SYNC), .W(HW)) u_hdec (
        .cnt(col_o), .vis(h_vis), .sync_act(h_sync)
    );

    span_decode #(.VIS(V_VIS), .FRONT(V_FRONT), .SYNC(V_SYNC), .W(VW)) u_vdec (
        .cnt(row_o), .vis(v_vis), .sync_act(v_sync)
    );

    always_comb begin
        flags.vis    = h_vis && v_vis;
        flags.hs_act = h_sync;
        flags.vs_act = v_sync;
    end

    pixel_gate u_gate (
        .clk(clk), .rst(rst), .flags(flags), .pix_i(rgb332_t'(rgb_i)),
        .pix_o(pix_out), .de_o(de_o), .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o)
    );

    assign rgb_o = pix_out;

    // R3: row steps by one at each line end, wraps at frame end
    assert_row_step_R3: assert property (@(posedge clk) disable iff (rst)
        (h_last && !v_last) |=> (row_o == $past(row_o) + 1'b1))
        else $error("row did not advance");

    assert_row_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (h_last && v_last) |=> (row_o == '0))
        else $error("row did not wrap");

    // R4: horizontal pulse starts and ends at the decoded columns
    assert_hsync_start_R4: assert property (@(posedge clk) disable iff (rst)
        (col_o == HW'(H_SYNC_LO)) |=> !hsync_n_o)
        else $error("hsync did not start");

    assert_hsync_end_R4: assert property (@(posedge clk) disable iff (rst)
        (col_o == HW'(H_SYNC_HI)) |=> hsync_n_o)
        else $error("hsync did not end");

    // R5: vertical pulse active on the first sync row
    assert_vsync_start_R5: assert property (@(posedge clk) disable iff (rst)
        (row_o == VW'(V_SYNC_LO)) |=> !vsync_n_o)
        else $error("vsync not active");

    // R6: enable low one clock after any column past the visible span
    assert_de_hblank_R6: assert property (@(posedge clk) disable iff (rst)
        (col_o >= HW'(H_VIS)) |=> !de_o)
        else $error("enable high in blanking");

endmodule

// File: tb/sim_vga_raster_sync.sv
module sim_vga_raster_sync;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rgb_in = '0;
    int         n = 0;
    int         checks = 0;
    int         fails = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    logic [9:0] c0, r0;
    logic       de0, hs0, vs0;
    logic [7:0] p0;
    logic [3:0] c1, r1;
    logic       de1, hs1, vs1;
    logic [7:0] p1;

    vga_raster_sync u0 (
        .clk(clk), .rst(rst), .rgb_i(rgb_in), .col_o(c0), .row_o(r0),
        .de_o(de0), .hsync_n_o(hs0), .vsync_n_o(vs0), .rgb_o(p0)
    );

    // R9: small geometry, 15 clocks per line, 9 lines per frame
    vga_raster_sync #(
        .H_VIS(8), .H_FRONT(2), .H_SYNC(3), .H_BACK(2),
        .V_VIS(4), .V_FRONT(1), .V_SYNC(2), .V_BACK(2)
    ) u1 (
        .clk(clk), .rst(rst), .rgb_i(rgb_in), .col_o(c1), .row_o(r1),
        .de_o(de1), .hsync_n_o(hs1), .vsync_n_o(vs1), .rgb_o(p1)
    );

    function automatic logic [7:0] pat(int m);
        return 8'((m * 37 + 11) ^ (m >> 3));
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (n=%0d)", tag, act, exp, n);
        end
    endtask

    task automatic cmp(string pre, int hv, int hf, int hs, int hb,
                       int vv, int vf, int vs, int vb,
                       int col, int row, bit de, bit hsn, bit vsn, int rgb);
        int ht = hv + hf + hs + hb;
        int vt = vv + vf + vs + vb;
        if (n == 0) begin
            chk(col == 0, {pre, " R1/R8 column"}, col, 0);
            chk(row == 0, {pre, " R1/R8 row"}, row, 0);
            chk(hsn && vsn, {pre, " R1/R8 syncs idle"}, {hsn, vsn}, 3);
            chk(!de, {pre, " R1/R8 enable"}, de, 0);
            chk(rgb == 0, {pre, " R1/R8 colour"}, rgb, 0);
        end else begin
            int m  = n - 1;
            int pc = m % ht;
            int pr = (m / ht) % vt;
            bit ed = (pc < hv) && (pr < vv);
            chk(col == n % ht, {pre, " R2 column"}, col, n % ht);
            chk(row == (n / ht) % vt, {pre, " R3 row"}, row, (n / ht) % vt);
            chk(hsn == !((pc >= hv + hf) && (pc < hv + hf + hs)),
                {pre, " R4 hsync_n"}, hsn, !((pc >= hv + hf) && (pc < hv + hf + hs)));
            chk(vsn == !((pr >= vv + vf) && (pr < vv + vf + vs)),
                {pre, " R5 vsync_n"}, vsn, !((pr >= vv + vf) && (pr < vv + vf + vs)));
            chk(de == ed, {pre, " R6 enable"}, de, ed);
            chk(rgb == (ed ? int'(pat(m)) : 0), {pre, " R7 colour"}, rgb,
                ed ? int'(pat(m)) : 0);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cmp("u0", 640, 16, 96, 48, 480, 10, 2, 29,
            int'(c0), int'(r0), de0, hs0, vs0, int'(p0));
        cmp("u1 R9", 8, 2, 3, 2, 4, 1, 2, 2,
            int'(c1), int'(r1), de1, hs1, vs1, int'(p1));
        rgb_in = pat(n);
    endtask

    task automatic t_reset_state();   // R1
        rst = 1'b1;
        repeat (5) step();
        rst = 1'b0;
    endtask

    task automatic t_default_lines(); // R2 R3 R4 R6 R7 at full geometry
        repeat (3 * 800 + 20) step();
        chk(r0 == 10'd3, "u0 R3 row after three lines", int'(r0), 3);
    endtask

    task automatic t_small_frames();  // R9 R5 R3 wrap over many frames
        repeat (300) step();
    endtask

    task automatic t_mid_reset();     // R8
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        repeat (200) step();
    endtask

    initial begin
        t_reset_state();
        t_default_lines();
        t_small_frames();
        t_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule